// File: doc/BRIEF.md
# Tick-Timed Switch Debouncer

This block turns the noisy level of one mechanical switch into a clean level. The raw pin is first brought into the system clock domain through a chain of flip-flops. A change detector compares the synchronized level with a registered copy on every system clock, not only on tick cycles. Any difference marks the input as unsettled and restarts a settle counter.

The settle counter advances only on cycles where an external slow tick is high. That tick usually comes from a shared prescaler at about 1 kHz. The clean output follows the input only after the level has held still for more than the settle count. Every bounce restarts the count, so a burst of bounces produces one update, placed after the last bounce. A one-cycle pulse marks each cycle in which the clean level takes a new value. With a 1 ms tick, the default count of 20 gives about 20 ms of settling. Useful settings lie between 10 and 20 ms.

Top module: `switch_debouncer`

## Requirements
- R1: During and right after synchronous reset (`rst` high), `sw_level` and `sw_changed` are 0. The synchronizer, the stored copy and the pending flag also clear to 0.
- R2: A change on `sw_raw` reaches the change detector after `SYNC_STAGES` clock edges. With a tick on every cycle, the pulse arrives `SYNC_STAGES + SETTLE_TICKS + 2` edges after the edge that first samples a clean change.
- R3: A detected change sets the pending flag and clears the settle counter. This happens whatever the value of `tick` is in that cycle.
- R4: While a change is pending, the settle counter advances by one on each clock edge with `tick` high. It holds on edges with `tick` low, however long the tick stays low.
- R5: On the tick that finds the counter equal to `SETTLE_TICKS` (the counter has passed the threshold), the pending flag clears and `sw_level` takes the synchronized input level.
- R6: Each new bounce restarts the count. The output therefore updates only after the final bounce plus the full settle time.
- R7: `sw_changed` is high for exactly one clock, in the same cycle that `sw_level` first shows its new value. `sw_level` never changes without it.
- R8: A glitch that returns to the old level before the settle time runs out leaves `sw_level` unchanged and produces no `sw_changed` pulse.
- R9: `tick` pulses while no change is pending have no effect on `sw_level` or `sw_changed`.
- R10: A change seen in the same cycle as a tick takes priority over counting or acceptance.
- R11: The settle counter never exceeds `SETTLE_TICKS`, so it cannot wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_raw | input | 1 | Unsynchronized switch level |
| tick | input | 1 | Slow timing enable, one clock wide |
| sw_level | output | 1 | Debounced switch level |
| sw_changed | output | 1 | One-clock pulse when `sw_level` takes a new value |

## Verification
The bench builds the block with `SETTLE_TICKS` = 3 and `SYNC_STAGES` = 3. This keeps a full settle window at a handful of cycles, so many bursts, glitches and long tick gaps fit in a short run. The three-stage chain exercises the generated synchronizer beyond its minimum depth.

With a tick on every clock, the latency formula can be checked exactly. Bounces spaced shorter than the window reliably collide with tick edges, which exercises the priority rule. Sparse and stalled ticks cover counter holding.

// File: rtl/db_pkg.sv
package db_pkg;

   typedef enum logic {
      DB_IDLE     = 1'b0,
      DB_SETTLING = 1'b1
   } db_state_e;

   // Bits needed to hold 0..max_count without wrap.
   function automatic int db_count_bits(input int max_count);
      int bits;
      bits = 1;
      while ((1 << bits) <= max_count) bits++;
      return bits;
   endfunction

endpackage

// File: rtl/db_sync.sv
module db_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] stage_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= 1'b0;
            else     stage_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[g] <= 1'b0;
            else     stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/db_change_det.sv
module db_change_det (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic held_o,
   output logic change_o
);

   logic held_q;

   always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= level_i;
   end

   assign held_o   = held_q;
   assign change_o = (level_i != held_q);

endmodule

// File: rtl/db_settle_timer.sv
module db_settle_timer
   import db_pkg::*;
#(
   parameter int SETTLE_TICKS = 20
) (
   input  logic clk,
   input  logic rst,
   input  logic change_i,
   input  logic held_i,
   input  logic tick_i,
   output logic level_o,
   output logic accept_o
);

   localparam int CNT_W = db_count_bits(SETTLE_TICKS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_TICKS);

   db_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             level_q;
   logic             accept_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= DB_IDLE;
         cnt_q    <= '0;
         level_q  <= 1'b0;
         accept_q <= 1'b0;
      end else begin
         accept_q <= 1'b0;
         if (change_i) begin
            state_q <= DB_SETTLING;
            cnt_q   <= '0;
         end else if (state_q == DB_SETTLING && tick_i) begin
            if (cnt_q == CNT_LAST) begin
               state_q  <= DB_IDLE;
               cnt_q    <= '0;
               level_q  <= held_i;
               accept_q <= (held_i != level_q);
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign level_o  = level_q;
   assign accept_o = accept_q;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_LAST); // R11

   AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
      change_i |=> (cnt_q == '0 && state_q == DB_SETTLING)); // R3

   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
      (state_q == DB_SETTLING && !tick_i && !change_i) |=>
         ($stable(cnt_q) && state_q == DB_SETTLING)); // R4

   AST_IDLE_IGNORES_TICK: assert property (@(posedge clk) disable iff (rst)
      (state_q == DB_IDLE && !change_i) |=> ($stable(level_q) && !accept_q)); // R9

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      accept_q |=> !accept_q); // R7

   AST_LEVEL_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
      !$stable(level_q) |-> accept_q); // R7

endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer #(
   parameter int SETTLE_TICKS = 20,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic sw_raw,
   input  logic tick,
   output logic sw_level,
   output logic sw_changed
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("switch_debouncer: SYNC_STAGES must be at least 2");
   end
   if (SETTLE_TICKS < 1) begin : g_bad_settle
      $error("switch_debouncer: SETTLE_TICKS must be at least 1");
   end

   logic sync_lvl;
   logic held_lvl;
   logic change;

   db_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (sw_raw),
      .q_sync  (sync_lvl)
   );

   db_change_det u_det (
      .clk      (clk),
      .rst      (rst),
      .level_i  (sync_lvl),
      .held_o   (held_lvl),
      .change_o (change)
   );

   db_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .change_i (change),
      .held_i   (held_lvl),
      .tick_i   (tick),
      .level_o  (sw_level),
      .accept_o (sw_changed)
   );

   AST_RESET_CLEAN: assert property (@(posedge clk)
      rst |=> (!sw_level && !sw_changed)); // R1

endmodule

// File: tb/sim_switch_debouncer.sv
module sim_switch_debouncer;

   localparam int T = 3;
   localparam int S = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sw_raw = 1'b0;
   logic tick = 1'b0;
   logic sw_level;
   logic sw_changed;

   int vectors = 0;
   int fails   = 0;
   int tick_mode = 0;   // 0: every cycle, 1: every 4th cycle, 2: stalled
   int tick_phase = 0;
   int pulse_count = 0;
   bit done = 0;

   always #4 clk = ~clk;  // 125 MHz

   switch_debouncer #(.SETTLE_TICKS(T), .SYNC_STAGES(S)) u0 (
      .clk(clk), .rst(rst), .sw_raw(sw_raw), .tick(tick),
      .sw_level(sw_level), .sw_changed(sw_changed)
   );

   // behavioural reference
   int m_pipe[$];
   int m_last, m_flag, m_cnt, m_level, m_pulse;

   initial begin
      for (int i = 0; i < S; i++) m_pipe.push_back(0);
   end

   always @(posedge clk) begin
      int s_out, p;
      if (rst) begin
         for (int i = 0; i < S; i++) m_pipe[i] = 0;
         m_last = 0; m_flag = 0; m_cnt = 0; m_level = 0; m_pulse = 0;
      end else begin
         s_out = m_pipe[S-1];
         p = 0;
         if (s_out != m_last) begin           // R3, R10: change wins
            m_flag = 1; m_cnt = 0;
         end else if (m_flag != 0 && tick) begin
            if (m_cnt == T) begin
               m_flag = 0; m_cnt = 0;
               p = (m_last != m_level) ? 1 : 0;
               m_level = m_last;
            end else m_cnt++;
         end
         m_pulse = p;
         m_last = s_out;
         void'(m_pipe.pop_back());
         m_pipe.push_front(int'(sw_raw));
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (!rst && !done) begin
         vectors++;
         if (int'(sw_level) != m_level) begin
            fails++;
            $display("FAIL R5 level: got %0d expected %0d at %0t", sw_level, m_level, $time);
         end
         if (int'(sw_changed) != m_pulse) begin
            fails++;
            $display("FAIL R7 pulse: got %0d expected %0d at %0t", sw_changed, m_pulse, $time);
         end
         if (sw_changed) pulse_count++;
      end
   end

   // tick driver
   always @(negedge clk) begin
      tick_phase++;
      case (tick_mode)
         0: tick <= 1'b1;
         1: tick <= (tick_phase % 4 == 0);
         default: tick <= 1'b0;
      endcase
   end

   task automatic check(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic drive(input logic v);
      @(negedge clk);
      sw_raw = v;
   endtask

   // edges from a raw change until the pulse is seen
   task automatic latency(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sw_changed && n < 200);
   endtask

   initial begin
      int lat, pc;
      cycles(3);
      // R1: reset state
      check("R1 level in reset", int'(sw_level), 0);
      check("R1 pulse in reset", int'(sw_changed), 0);
      @(negedge clk); rst = 1'b0;
      cycles(2);
      check("R1 level after reset", int'(sw_level), 0);

      // R9: ticks with nothing pending
      pc = pulse_count;
      cycles(20);
      check("R9 no pulse while idle", pulse_count - pc, 0);
      check("R9 level idle", int'(sw_level), 0);

      // R2, R5: clean press with a tick every cycle
      drive(1'b1);
      latency(lat);
      check("R2/R5 press latency", lat, S + T + 2);
      check("R5 level after press", int'(sw_level), 1);
      @(negedge clk);
      check("R7 pulse one cycle", int'(sw_changed), 0);

      // R6, R10: bouncing release, spacing below the window
      cycles(10);
      drive(1'b0); cycles(1);
      drive(1'b1); cycles(2);
      drive(1'b0); cycles(1);
      drive(1'b1); cycles(3);
      check("R6 level held during bounce", int'(sw_level), 1);
      drive(1'b0);
      latency(lat);
      check("R6 latency from final bounce", lat, S + T + 2);
      check("R6 level after bounce", int'(sw_level), 0);

      // R8: glitch that returns
      cycles(10);
      pc = pulse_count;
      drive(1'b1); cycles(2);
      drive(1'b0);
      cycles(30);
      check("R8 glitch no pulse", pulse_count - pc, 0);
      check("R8 glitch level", int'(sw_level), 0);

      // R4: sparse ticks
      tick_mode = 1;
      drive(1'b1);
      cycles(60);
      check("R4 level with sparse ticks", int'(sw_level), 1);
      drive(1'b0); cycles(5);
      drive(1'b1); cycles(5);
      drive(1'b0);
      cycles(60);
      check("R4 level after sparse bounce", int'(sw_level), 0);

      // R4: tick stalled, output must not move
      tick_mode = 2;
      drive(1'b1);
      cycles(80);
      check("R4 no accept while tick stalled", int'(sw_level), 0);
      tick_mode = 0;
      cycles(S + T + 6);
      check("R4 accept once ticks resume", int'(sw_level), 1);

      // R10: rapid toggling every cycle with ticks every cycle
      for (int k = 0; k < 12; k++) drive(k[0]);
      drive(1'b1);
      cycles(30);
      check("R10 level after rapid toggling", int'(sw_level), 1);

      // R1: reset mid-operation
      @(negedge clk); rst = 1'b1;
      cycles(2);
      check("R1 level after late reset", int'(sw_level), 0);
      check("R1 pulse after late reset", int'(sw_changed), 0);
      @(negedge clk); rst = 1'b0;
      cycles(30);   // raw still 1: accepted again
      check("R5 reaccept after reset", int'(sw_level), 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule